// File: doc/BRIEF.md
# Auto-Claiming Fixed-Priority Interrupt Controller

The block gathers a parameterized number of level-sensitive interrupt lines and routes them to a parameterized number of processors. A line counts as pending while its input is high or its software-trigger bit is set. A pending line whose mask bit is clear is delivered to every processor named in its one-hot route register.

Each processor has its own register port, and port c is the view of processor c. A read of the claim register returns the lowest-numbered line that is deliverable to that processor, and the same access sets that line's mask bit. No acknowledge write is needed, and the line stays quiet until software clears the mask again. Each processor has one interrupt output, which is high while anything is deliverable to it.

Read data comes back from a register one cycle after the read and stays there until the next read on that port. Writes take effect at the clock edge that samples them. When two ports write in the same cycle, a set beats a clear, and for a route register the lower port wins.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every mask bit is set, every software-trigger bit is clear, every route register reads 1 (processor 0) and every `cpu_irq_o` bit is low.
- R2: A read of byte address 0x0000 returns the number of implemented lines in bits 15:0 and zero above.
- R3: Line n is pending when `hw_irq_i[n]` is high or its software-trigger bit is set. Writing ones to 0x0200+4*(n>>5) sets trigger bit n&31 of that word, and writing ones to 0x0280+4*(n>>5) clears it. A read of either address returns the trigger word.
- R4: Writing ones to 0x0100+4*(n>>5) sets mask bits, and writing ones to 0x0180+4*(n>>5) clears them, with bit n&31 standing for line n. A read of either address returns the mask word. A masked line is never delivered.
- R5: The route register of line n is at 0x1000+4*n. When its bit c is set, line n is delivered to processor c and to no processor whose bit is clear.
- R6: A read of 0x0004 on port c returns 0x0001_0000 | n, where n is the lowest-numbered line that is pending, unmasked and routed to c. Bits 31:24 are 0, bits 23:16 hold type 1, and n is always below the line count. The read returns 0 when no such line exists.
- R7: A claim read that returns line n sets mask bit n in that same access.
- R8: `cpu_irq_o[c]` is a registered output. It is high while some line is deliverable to c. It follows an input or register change at the next clock edge, and it falls at the edge that completes the claim of the last deliverable line.
- R9: When several ports read the claim register in the same cycle and one line is deliverable to more than one of them, the lowest-numbered port gets that line. The other ports get their next-lowest line, or 0 if they have none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hw_irq_i | input | NUM_IRQ | Level-sensitive interrupt lines |
| bus_rd_i | input | NUM_CPU | Read strobe, one per port |
| bus_wr_i | input | NUM_CPU | Write strobe, one per port |
| bus_addr_i | input | 16*NUM_CPU | Byte address, 16 bits per port |
| bus_wdata_i | input | 32*NUM_CPU | Write data, 32 bits per port |
| bus_rdata_o | output | 32*NUM_CPU | Registered read data, 32 bits per port |
| cpu_irq_o | output | NUM_CPU | Interrupt request, one per processor |

## Verification
A mask bit that the claim fails to set shows up one read later: the claim register returns the same number twice and the interrupt output stays high. Route or priority errors show within a cycle, either as a request on the wrong `cpu_irq_o` bit or as claim numbers that do not rise strictly while a fully pending bank drains. A fault in the same-cycle arbitration shows in the first joint read, because both ports return the same line.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADR_INFO  = 16'h0000;
  localparam logic [ADDR_W-1:0] ADR_CLAIM = 16'h0004;
  localparam logic [7:0]        PAGE_MASK = 8'h01;
  localparam logic [7:0]        PAGE_TRIG = 8'h02;
  localparam logic [3:0]        PAGE_ROUTE = 4'h1;
  localparam logic [7:0]        EVT_TYPE_HW = 8'h01;

  typedef struct packed {
    logic info_rd;
    logic claim_rd;
    logic mask_rd;
    logic trig_rd;
    logic route_rd;
    logic mask_set;
    logic mask_clr;
    logic trig_set;
    logic trig_clr;
    logic route_wr;
  } dec_t;
endpackage

// File: rtl/lvl_irq_pick.sv
// Lowest-set-bit finder: index, one-hot and found flag.
module lvl_irq_pick #(
  parameter int N = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign onehot_o = vec_i & (~vec_i + N'(1));
endmodule

// File: rtl/lvl_irq_claim.sv
// Chained arbitration: each processor picks among the lines that
// lower-numbered claiming processors have not taken this cycle.
module lvl_irq_claim #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_CPU*NUM_IRQ-1:0] elig_i,
  input  logic [NUM_CPU-1:0]         req_i,
  output logic [NUM_CPU-1:0]         found_o,
  output logic [NUM_CPU*IDX_W-1:0]   idx_o,
  output logic [NUM_IRQ-1:0]         taken_o
);
  logic [NUM_IRQ-1:0] avail [NUM_CPU+1];

  assign avail[0] = '1;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] cand;
    logic [NUM_IRQ-1:0] oh;
    assign cand = elig_i[c*NUM_IRQ +: NUM_IRQ] & avail[c];
    lvl_irq_pick #(.N(NUM_IRQ)) pick_i (
      .vec_i   (cand),
      .found_o (found_o[c]),
      .idx_o   (idx_o[c*IDX_W +: IDX_W]),
      .onehot_o(oh)
    );
    assign avail[c+1] = avail[c] & ~(req_i[c] ? oh : '0);
  end

  assign taken_o = ~avail[NUM_CPU];
endmodule

// File: rtl/lvl_irq_decode.sv
// Address decode for one register port.
module lvl_irq_decode
  import lvl_irq_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int NUM_WORDS = (NUM_IRQ + 31) / 32,
  localparam int WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o,
  output logic [WORD_W-1:0] word_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic aligned, word_ok, idx_ok, in_mask, in_trig, in_route;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign word_ok  = (32'(addr_i[6:2]) < NUM_WORDS);
  assign idx_ok   = (32'(addr_i[11:2]) < NUM_IRQ);
  assign in_mask  = aligned && (addr_i[15:8] == PAGE_MASK) && word_ok;
  assign in_trig  = aligned && (addr_i[15:8] == PAGE_TRIG) && word_ok;
  assign in_route = aligned && (addr_i[15:12] == PAGE_ROUTE) && idx_ok;

  assign word_o = addr_i[2 +: WORD_W];
  assign idx_o  = addr_i[2 +: IDX_W];

  always_comb begin
    dec_o          = '0;
    dec_o.info_rd  = rd_i && (addr_i == ADR_INFO);
    dec_o.claim_rd = rd_i && (addr_i == ADR_CLAIM);
    dec_o.mask_rd  = rd_i && in_mask;
    dec_o.trig_rd  = rd_i && in_trig;
    dec_o.route_rd = rd_i && in_route;
    dec_o.mask_set = wr_i && in_mask && !addr_i[7];
    dec_o.mask_clr = wr_i && in_mask && addr_i[7];
    dec_o.trig_set = wr_i && in_trig && !addr_i[7];
    dec_o.trig_clr = wr_i && in_trig && addr_i[7];
    dec_o.route_wr = wr_i && in_route;
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic [NUM_IRQ-1:0]        hw_irq_i,
  input  logic [NUM_CPU-1:0]        bus_rd_i,
  input  logic [NUM_CPU-1:0]        bus_wr_i,
  input  logic [NUM_CPU*ADDR_W-1:0] bus_addr_i,
  input  logic [NUM_CPU*DATA_W-1:0] bus_wdata_i,
  output logic [NUM_CPU*DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CPU-1:0]        cpu_irq_o
);
  localparam int NUM_WORDS = (NUM_IRQ + 31) / 32;
  localparam int WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int PAD_W = NUM_WORDS * 32;

  logic [NUM_IRQ-1:0] mask_q, trig_q;
  logic [NUM_CPU-1:0] route_q [NUM_IRQ];
  logic [NUM_CPU-1:0] irq_q;
  logic [DATA_W-1:0]  rdata_q [NUM_CPU];

  dec_t              dec_s  [NUM_CPU];
  logic [WORD_W-1:0] word_s [NUM_CPU];
  logic [IDX_W-1:0]  idx_s  [NUM_CPU];
  logic [NUM_CPU-1:0] claim_rd, info_rd;

  for (genvar p = 0; p < NUM_CPU; p++) begin : g_dec
    lvl_irq_decode #(.NUM_IRQ(NUM_IRQ)) dec_i (
      .rd_i  (bus_rd_i[p]),
      .wr_i  (bus_wr_i[p]),
      .addr_i(bus_addr_i[p*ADDR_W +: ADDR_W]),
      .dec_o (dec_s[p]),
      .word_o(word_s[p]),
      .idx_o (idx_s[p])
    );
    assign claim_rd[p] = dec_s[p].claim_rd;
    assign info_rd[p]  = dec_s[p].info_rd;
  end

  // Deliverable lines per processor from the current state.
  logic [NUM_IRQ-1:0]         pend;
  logic [NUM_CPU*NUM_IRQ-1:0] elig;
  assign pend = hw_irq_i | trig_q;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int n = 0; n < NUM_IRQ; n++) begin
        elig[c*NUM_IRQ + n] = pend[n] & ~mask_q[n] & route_q[n][c];
      end
    end
  end

  logic [NUM_CPU-1:0]       win_found;
  logic [NUM_CPU*IDX_W-1:0] win_idx;
  logic [NUM_IRQ-1:0]       taken;

  lvl_irq_claim #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) claim_i (
    .elig_i (elig),
    .req_i  (claim_rd),
    .found_o(win_found),
    .idx_o  (win_idx),
    .taken_o(taken)
  );

  // Write-one set/clear vectors gathered from all ports.
  logic [NUM_IRQ-1:0] mset_v, mclr_v, tset_v, tclr_v;
  always_comb begin
    mset_v = '0;
    mclr_v = '0;
    tset_v = '0;
    tclr_v = '0;
    for (int p = 0; p < NUM_CPU; p++) begin
      for (int n = 0; n < NUM_IRQ; n++) begin
        if (word_s[p] == WORD_W'(n / 32)) begin
          if (dec_s[p].mask_set) mset_v[n] = mset_v[n] | bus_wdata_i[p*DATA_W + (n % 32)];
          if (dec_s[p].mask_clr) mclr_v[n] = mclr_v[n] | bus_wdata_i[p*DATA_W + (n % 32)];
          if (dec_s[p].trig_set) tset_v[n] = tset_v[n] | bus_wdata_i[p*DATA_W + (n % 32)];
          if (dec_s[p].trig_clr) tclr_v[n] = tclr_v[n] | bus_wdata_i[p*DATA_W + (n % 32)];
        end
      end
    end
  end

  // Next state: sets (and claims) beat clears; the lowest port wins a route write.
  logic [NUM_IRQ-1:0] mask_d, trig_d;
  logic [NUM_CPU-1:0] route_d [NUM_IRQ];
  logic [NUM_CPU-1:0] irq_d;

  assign mask_d = (mask_q & ~mclr_v) | mset_v | taken;
  assign trig_d = (trig_q & ~tclr_v) | tset_v;

  always_comb begin
    for (int n = 0; n < NUM_IRQ; n++) route_d[n] = route_q[n];
    for (int p = NUM_CPU - 1; p >= 0; p--) begin
      if (dec_s[p].route_wr) route_d[idx_s[p]] = bus_wdata_i[p*DATA_W +: NUM_CPU];
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      irq_d[c] = 1'b0;
      for (int n = 0; n < NUM_IRQ; n++) begin
        irq_d[c] = irq_d[c] | ((hw_irq_i[n] | trig_d[n]) & ~mask_d[n] & route_d[n][c]);
      end
    end
  end

  // Read data per port.
  logic [PAD_W-1:0]  mask_pad, trig_pad;
  logic [DATA_W-1:0] rd_val [NUM_CPU];
  assign mask_pad = PAD_W'(mask_q);
  assign trig_pad = PAD_W'(trig_q);

  for (genvar p = 0; p < NUM_CPU; p++) begin : g_rd
    always_comb begin
      rd_val[p] = '0;
      if (dec_s[p].info_rd)
        rd_val[p] = DATA_W'(NUM_IRQ);
      else if (dec_s[p].claim_rd && win_found[p])
        rd_val[p] = {8'h00, EVT_TYPE_HW, 16'(win_idx[p*IDX_W +: IDX_W])};
      else if (dec_s[p].mask_rd)
        rd_val[p] = mask_pad[{word_s[p], 5'b0} +: 32];
      else if (dec_s[p].trig_rd)
        rd_val[p] = trig_pad[{word_s[p], 5'b0} +: 32];
      else if (dec_s[p].route_rd)
        rd_val[p] = DATA_W'(route_q[idx_s[p]]);
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) rdata_q[p] <= '0;
      else if (bus_rd_i[p]) rdata_q[p] <= rd_val[p];
    end

    assign bus_rdata_o[p*DATA_W +: DATA_W] = rdata_q[p];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_q <= '1;
      trig_q <= '0;
      irq_q  <= '0;
      for (int n = 0; n < NUM_IRQ; n++) route_q[n] <= NUM_CPU'(1);
    end else begin
      mask_q <= mask_d;
      trig_q <= trig_d;
      irq_q  <= irq_d;
      for (int n = 0; n < NUM_IRQ; n++) route_q[n] <= route_d[n];
    end
  end

  assign cpu_irq_o = irq_q;
endmodule

// File: rtl/lvl_irq_ctrl_checker.sv
module lvl_irq_ctrl_checker #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic                   clk_i,
  input logic                   rst_i,
  input logic [NUM_CPU-1:0]     claim_rd_i,
  input logic [NUM_CPU-1:0]     info_rd_i,
  input logic [NUM_CPU*32-1:0]  rdata_i,
  input logic [NUM_CPU-1:0]     irq_i,
  input logic [NUM_IRQ-1:0]     mask_i
);
  // R1: the first cycle after reset has every line masked and no request.
  assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (irq_i == '0) && (&mask_i));

  // R8: a request cannot be up while every line is masked.
  assert_irq_needs_unmasked_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_i != '0) |-> !(&mask_i));

  for (genvar p = 0; p < NUM_CPU; p++) begin : g_port
    // R2
    assert_info_value_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(info_rd_i[p]) |-> (rdata_i[p*32 +: 32] == 32'(NUM_IRQ)));

    // R6: claim word is zero or a hardware-type word with an in-range number.
    assert_claim_format_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(claim_rd_i[p]) |->
        (rdata_i[p*32 +: 32] == 32'h0) ||
        ((rdata_i[p*32+16 +: 16] == 16'h0001) && (32'(rdata_i[p*32 +: 16]) < NUM_IRQ)));

    // R7: the returned line is masked once the claim completes.
    assert_claim_masks_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(claim_rd_i[p]) && (rdata_i[p*32+16 +: 16] == 16'h0001)) |->
        mask_i[rdata_i[p*32 +: IDX_W]]);

    for (genvar q = p + 1; q < NUM_CPU; q++) begin : g_pair
      // R9: two same-cycle claims never return the same line.
      assert_distinct_claim_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(claim_rd_i[p] && claim_rd_i[q]) &&
         (rdata_i[p*32+16 +: 16] == 16'h0001) && (rdata_i[q*32+16 +: 16] == 16'h0001)) |->
          (rdata_i[p*32 +: 16] != rdata_i[q*32 +: 16]));
    end
  end
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_checker #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .claim_rd_i(claim_rd),
  .info_rd_i (info_rd),
  .rdata_i   (bus_rdata_o),
  .irq_i     (cpu_irq_o),
  .mask_i    (mask_q)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;
  localparam int NI = 64;
  localparam int NC = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NI-1:0]  hw = '0;
  logic [NC-1:0]  rd = '0;
  logic [NC-1:0]  wr = '0;
  logic [NC*16-1:0] addr = '0;
  logic [NC*32-1:0] wdata = '0;
  logic [NC*32-1:0] rdata;
  logic [NC-1:0]  irq;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  lvl_irq_ctrl #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut_i (
    .clk_i(clk), .rst_i(rst), .hw_irq_i(hw),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .cpu_irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic do_write(int p, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wr[p] = 1'b1;
    addr[p*16 +: 16] = a;
    wdata[p*32 +: 32] = d;
    @(negedge clk);
    wr[p] = 1'b0;
  endtask

  task automatic do_read(int p, logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    rd[p] = 1'b1;
    addr[p*16 +: 16] = a;
    @(negedge clk);
    rd[p] = 1'b0;
    d = rdata[p*32 +: 32];
  endtask

  task automatic dual_read(int p, int q, logic [15:0] a,
                           output logic [31:0] dp, output logic [31:0] dq);
    @(negedge clk);
    rd[p] = 1'b1; rd[q] = 1'b1;
    addr[p*16 +: 16] = a; addr[q*16 +: 16] = a;
    @(negedge clk);
    rd[p] = 1'b0; rd[q] = 1'b0;
    dp = rdata[p*32 +: 32];
    dq = rdata[q*32 +: 32];
  endtask

  function automatic logic [15:0] wadr(int base, int w);
    return 16'(base + 4 * w);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'h0);
    for (int w = 0; w < 2; w++) begin
      do_read(0, wadr(32'h100, w), d); chk("R1 mask word", d, 32'hffff_ffff);
      do_read(1, wadr(32'h200, w), d); chk("R1 trigger word", d, 32'h0);
    end
    for (int n = 0; n < NI; n++) begin
      do_read(n % NC, wadr(32'h1000, n), d); chk("R1 route reset", d, 32'h1);
    end

    // R2 info
    do_read(2, 16'h0000, d); chk("R2 info", d, 32'(NI));

    // R4/R6 all pending but masked: nothing delivered, claim reads zero
    hw = '1;
    @(negedge clk);
    chk("R4 masked not delivered", 32'(irq), 32'h0);
    do_read(0, 16'h0004, d); chk("R6 empty claim", d, 32'h0);
    hw = '0;

    // R6/R7/R8 each line alone on processor 0
    for (int n = 0; n < NI; n++) begin
      hw = NI'(1) << n;
      @(negedge clk);
      chk("R4 line masked", 32'(irq), 32'h0);
      do_write(0, wadr(32'h180, n / 32), 32'h1 << (n % 32));
      chk("R8 irq rises", 32'(irq), 32'h1);
      do_read(0, 16'h0004, d); chk("R6 claim number", d, 32'h0001_0000 | 32'(n));
      chk("R8 irq falls after claim", 32'(irq), 32'h0);
      do_read(0, wadr(32'h180, n / 32), d);
      chk("R7 claim sets mask", d & (32'h1 << (n % 32)), 32'h1 << (n % 32));
      hw = '0;
    end

    // R6 priority: all lines pending, drained in ascending order
    hw = '1;
    do_write(1, wadr(32'h180, 0), 32'hffff_ffff);
    do_write(1, wadr(32'h180, 1), 32'hffff_ffff);
    chk("R8 irq with full bank", 32'(irq), 32'h1);
    for (int n = 0; n < NI; n++) begin
      do_read(0, 16'h0004, d); chk("R6 ascending claim", d, 32'h0001_0000 | 32'(n));
    end
    chk("R8 irq after drain", 32'(irq), 32'h0);
    do_read(0, 16'h0004, d); chk("R7 drained claim zero", d, 32'h0);
    hw = '0;

    // R5/R3 routing line n to processor n%4 with software triggers
    for (int n = 0; n < NI; n++) do_write(3, wadr(32'h1000, n), 32'h1 << (n % NC));
    do_read(0, wadr(32'h1000, 7), d); chk("R5 route readback", d, 32'h8);
    do_write(2, wadr(32'h200, 0), 32'hffff_ffff);
    do_write(2, wadr(32'h200, 1), 32'hffff_ffff);
    do_read(1, wadr(32'h280, 1), d); chk("R3 trigger readback", d, 32'hffff_ffff);
    do_write(0, wadr(32'h180, 0), 32'hffff_ffff);
    do_write(0, wadr(32'h180, 1), 32'hffff_ffff);
    chk("R5 all processors requested", 32'(irq), 32'hf);
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < NI / NC; k++) begin
        do_read(c, 16'h0004, d);
        chk("R5 routed claim", d, 32'h0001_0000 | 32'(c + NC * k));
      end
      chk("R5 per-processor drain", 32'(irq), (32'hf << (c + 1)) & 32'hf);
    end

    // R3 trigger OR hardware, R4 mask set
    do_write(0, wadr(32'h180, 0), 32'h8);
    chk("R3 trigger delivers", 32'(irq), 32'h8);
    do_write(0, wadr(32'h280, 0), 32'h8);
    chk("R3 trigger clear", 32'(irq), 32'h0);
    hw[3] = 1'b1;
    @(negedge clk);
    chk("R3 hardware level", 32'(irq), 32'h8);
    do_write(1, wadr(32'h100, 0), 32'h8);
    chk("R4 mask set blocks", 32'(irq), 32'h0);
    hw = '0;
    do_write(0, wadr(32'h280, 0), 32'hffff_ffff);
    do_write(0, wadr(32'h280, 1), 32'hffff_ffff);
    do_read(0, wadr(32'h200, 0), d); chk("R3 trigger cleared", d, 32'h0);

    // R9 same-cycle claims
    do_write(0, wadr(32'h1000, 5), 32'h6);
    do_write(0, wadr(32'h1000, 9), 32'h4);
    do_write(0, wadr(32'h200, 0), 32'h220);
    do_write(0, wadr(32'h180, 0), 32'h220);
    chk("R5 shared route", 32'(irq), 32'h6);
    dual_read(1, 2, 16'h0004, d, d2);
    chk("R9 lower port wins", d, 32'h0001_0005);
    chk("R9 higher port next", d2, 32'h0001_0009);
    chk("R8 both drained", 32'(irq), 32'h0);
    do_write(0, wadr(32'h180, 0), 32'h20);
    dual_read(1, 2, 16'h0004, d, d2);
    chk("R9 lower port only", d, 32'h0001_0005);
    chk("R9 higher port empty", d2, 32'h0);
    chk("R8 idle after shared", 32'(irq), 32'h0);

    summary();
    $finish;
  end
endmodule